// File: doc/BRIEF.md
# PHY Management Interrupt Controller

This block is the interrupt corner of an Ethernet PHY's management logic. It receives clause-22 serial management frames on an MDC/MDIO pair, holds a latching interrupt source register and an interrupt enable register, and drives an active-low interrupt line to the host. Six PHY conditions arrive as level inputs. Each source bit sets on the edge that marks its condition and stays set until that condition goes away or until software reads it. A source bit pulls the interrupt line low only while its enable bit is also set.

The management slave samples MDC with the system clock. A frame needs a run of 32 ones, the start pair 0-1, an opcode (01 write, 10 read), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits, most significant bit first. The PHY address comes from a strap input at reset, and software can change it later. The slave also holds a control register with a self-clearing restart bit, a status register with live link and fault bits, and a mode register that carries the PHY address. Every other register address reads as zero.

Top module: `phy_irq_mgmt`

## Requirements
- R1: Writes and reads at the current PHY address reach register 30. In register 30, bits 7..2 are writable enables, and bits 15..8, 1 and 0 read 0. Register 2 reads 0, and a write to it has no effect.
- R2: The PHY address resets to {4'b0, strap_addr0}. Writing register 18 bits 4..0 sets a new address. A frame addressed elsewhere neither writes a register nor drives MDIO.
- R3: In a read, MDIO is released during the first turnaround bit and driven 0 during the second. The 16 data bits follow, MSB first, and MDIO is released after the last data bit.
- R4: A frame with a start pair other than 0-1, or with opcode 00 or 11, is ignored until a new run of 32 ones.
- R5: Register 29 bit 7 sets on a rising ev_energy, bit 6 on a rising ev_an_done, bit 5 on a rising ev_rfault, bit 3 on a rising ev_lp_ack and bit 2 on a rising ev_pd_fault. Bit 4 sets on a falling ev_link_up.
- R6: Source bits 7, 6, 5, 3 and 2 clear when their input falls.
- R7: Reading register 29 clears all source bits. Reading register 1 clears only bits 4 and 5. Bit 4 is not cleared when the link comes back up.
- R8: When a source sets in the same cycle that a read clears it, the set wins. The read returns the old value and the bit stays set.
- R9: irq_n is low exactly when some register 29 bit and the same register 30 bit are both 1. Clearing the enable bit releases irq_n.
- R10: Register 0 resets to 16'h1000, and its bit 9 reads 0 after being written 1. Register 1 reads 16'h7809 OR (ev_rfault<<4) OR (ev_link_up<<2).
- R11: After reset, irq_n is 1, mdio_oe is 0 and registers 29 and 30 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| strap_addr0 | input | 1 | Strap value for PHY address bit 0 at reset |
| mdc | input | 1 | Management clock from the host |
| mdio_in | input | 1 | Management data into the slave |
| mdio_out | output | 1 | Management data driven by the slave |
| mdio_oe | output | 1 | Output enable for mdio_out |
| ev_energy | input | 1 | Energy detected on the line (level) |
| ev_an_done | input | 1 | Auto-negotiation complete (level) |
| ev_rfault | input | 1 | Remote fault present (level) |
| ev_link_up | input | 1 | Link status (level) |
| ev_lp_ack | input | 1 | Link-partner acknowledge (level) |
| ev_pd_fault | input | 1 | Parallel detection fault (level) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can act on one source flop in the same cycle: the clear caused by reading register 29, and the set caused by a new rising edge of ev_rfault. The bench creates this collision by raising ev_rfault exactly on the system clock edge where the slave latches the register address bit of a read of register 29. That edge comes two synchroniser stages after the MDC rise. The outcome is judged from two sides. The colliding read must return bit 5 as 0, and a second read must return bit 5 as 1, which shows that the event was neither lost nor reported early.

// File: rtl/pim_pkg.sv
package pim_pkg;
  localparam int DW         = 16;
  localparam int AW         = 5;
  localparam int PRE_BITS   = 32;
  localparam int SRC_LO     = 2;
  localparam int SRC_HI     = 7;
  localparam int BIT_LINKDN = 4;
  localparam int BIT_RFAULT = 5;

  localparam logic [AW-1:0] REG_CTRL  = 5'd0;
  localparam logic [AW-1:0] REG_STAT  = 5'd1;
  localparam logic [AW-1:0] REG_MODES = 5'd18;
  localparam logic [AW-1:0] REG_ISRC  = 5'd29;
  localparam logic [AW-1:0] REG_IMSK  = 5'd30;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [2:0] {F_PRE, F_ST, F_OP, F_PA, F_RA, F_TA, F_WD, F_RD} frm_e;

  // status word: fixed ability bits plus live fault (bit 4) and link (bit 2)
  function automatic logic [DW-1:0] status_word(input logic link, input logic rf);
    return 16'h7809 | {11'b0, rf, 1'b0, link, 2'b0};
  endfunction

  function automatic logic irq_any(input logic [5:0] src, input logic [5:0] msk);
    return |(src & msk);
  endfunction
endpackage

// File: rtl/pim_sync.sv
module pim_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pim_mdio_slave.sv
module pim_mdio_slave
  import pim_pkg::*;
#(
  parameter int PRE = PRE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc_rise,
  input  logic          bit_in,
  input  logic [AW-1:0] my_addr,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] acc_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          mdio_out,
  output logic          mdio_oe
);
  localparam int OW = $clog2(PRE + 1);

  frm_e          st;
  logic [OW-1:0] ones;
  logic [3:0]    cnt;
  logic [14:0]   sh;
  logic [DW-1:0] tx;
  logic          is_rd;
  logic [AW-1:0] ra_q;
  logic          addr_hit;

  assign addr_hit = ({sh[3:0], bit_in} == my_addr);
  assign acc_addr = (st == F_RA) ? {sh[3:0], bit_in} : ra_q;
  assign rd_stb   = mdc_rise && (st == F_RA) && (cnt == 4'd4) && is_rd;
  assign wr_stb   = mdc_rise && (st == F_WD) && (cnt == 4'd15);
  assign wr_data  = {sh, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_PRE; ones <= '0; cnt <= '0; sh <= '0; tx <= '0;
      is_rd <= 1'b0; ra_q <= '0; mdio_out <= 1'b0; mdio_oe <= 1'b0;
    end else if (mdc_rise) begin
      sh <= {sh[13:0], bit_in};
      case (st)
        F_PRE: begin
          if (bit_in) begin
            if (ones != OW'(PRE)) ones <= ones + 1'b1;
          end else begin
            if (ones == OW'(PRE)) st <= F_ST;
            ones <= '0;
          end
        end
        F_ST: begin
          cnt <= '0;
          st  <= bit_in ? F_OP : F_PRE;
        end
        F_OP: begin
          if (cnt == 4'd0) cnt <= 4'd1;
          else begin
            cnt <= '0;
            if ({sh[0], bit_in} == OP_WR) begin
              is_rd <= 1'b0; st <= F_PA;
            end else if ({sh[0], bit_in} == OP_RD) begin
              is_rd <= 1'b1; st <= F_PA;
            end else st <= F_PRE;
          end
        end
        F_PA: begin
          if (cnt == 4'd4) begin
            cnt <= '0;
            st  <= addr_hit ? F_RA : F_PRE;
          end else cnt <= cnt + 1'b1;
        end
        F_RA: begin
          if (cnt == 4'd4) begin
            cnt  <= '0;
            ra_q <= {sh[3:0], bit_in};
            st   <= F_TA;
            if (is_rd) tx <= rd_data;
          end else cnt <= cnt + 1'b1;
        end
        F_TA: begin
          if (cnt == 4'd0) begin
            cnt <= 4'd1;
            if (is_rd) begin mdio_oe <= 1'b1; mdio_out <= 1'b0; end
          end else begin
            cnt <= '0;
            if (is_rd) begin
              mdio_out <= tx[DW-1]; tx <= {tx[DW-2:0], 1'b0}; st <= F_RD;
            end else st <= F_WD;
          end
        end
        F_WD: begin
          if (cnt == 4'd15) begin cnt <= '0; st <= F_PRE; end
          else cnt <= cnt + 1'b1;
        end
        F_RD: begin
          if (cnt == 4'd15) begin
            cnt <= '0; mdio_oe <= 1'b0; mdio_out <= 1'b0; st <= F_PRE;
          end else begin
            cnt <= cnt + 1'b1;
            mdio_out <= tx[DW-1]; tx <= {tx[DW-2:0], 1'b0};
          end
        end
        default: st <= F_PRE;
      endcase
    end
  end

  AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == F_TA || st == F_RD)); // R3
  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && st == F_TA) |-> !mdio_out); // R3
  AST_WRITE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !is_rd); // R2
endmodule

// File: rtl/pim_src_regs.sv
module pim_src_regs
  import pim_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_addr0,
  input  logic [SRC_HI:SRC_LO] ev_lvl,
  input  logic          link_up,
  input  logic          rfault,
  input  logic [AW-1:0] acc_addr,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] phy_addr,
  output logic          irq_n
);
  localparam logic [SRC_HI:SRC_LO] PREV_RST = 6'b000100; // link-down level idle high

  logic [SRC_HI:SRC_LO] prev, src, msk, set_e, clr_e, rclr;
  logic [DW-1:0]        ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= PREV_RST;
    else        prev <= ev_lvl;
  end

  for (genvar i = SRC_LO; i <= SRC_HI; i++) begin : g_src
    localparam bit STAT_CLR = (i == BIT_LINKDN) || (i == BIT_RFAULT);
    localparam bit EDGE_CLR = (i != BIT_LINKDN);
    assign set_e[i] = ev_lvl[i] & ~prev[i];
    assign clr_e[i] = EDGE_CLR & ~ev_lvl[i] & prev[i];
    assign rclr[i]  = rd_stb && (acc_addr == REG_ISRC || (STAT_CLR && acc_addr == REG_STAT));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   src[i] <= 1'b0;
      else if (set_e[i])            src[i] <= 1'b1;
      else if (clr_e[i] | rclr[i])  src[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk   <= '0;
      ctrl  <= 16'h1000;
      irq_n <= 1'b1;
    end else begin
      irq_n <= ~irq_any(src, msk);
      if (wr_stb && acc_addr == REG_IMSK) msk <= wr_data[SRC_HI:SRC_LO];
      if (wr_stb && acc_addr == REG_CTRL) ctrl <= wr_data;
      else if (ctrl[9])                   ctrl[9] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                phy_addr <= {4'b0, strap_addr0};
    else if (wr_stb && acc_addr == REG_MODES)  phy_addr <= wr_data[AW-1:0];
  end

  always_comb begin
    case (acc_addr)
      REG_CTRL:  rd_data = ctrl;
      REG_STAT:  rd_data = status_word(link_up, rfault);
      REG_MODES: rd_data = {11'b0, phy_addr};
      REG_ISRC:  rd_data = {8'b0, src, 2'b0};
      REG_IMSK:  rd_data = {8'b0, msk, 2'b0};
      default:   rd_data = '0;
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_e[BIT_RFAULT] |=> src[BIT_RFAULT]); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && acc_addr == REG_ISRC && set_e == '0) |=> (src == '0)); // R7
  AST_RESTART_SC: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[9] |=> !ctrl[9]); // R10
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !$past(irq_any(src, msk))); // R9
endmodule

// File: rtl/phy_irq_mgmt.sv
module phy_irq_mgmt
  import pim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_addr0,
  input  logic mdc,
  input  logic mdio_in,
  output logic mdio_out,
  output logic mdio_oe,
  input  logic ev_energy,
  input  logic ev_an_done,
  input  logic ev_rfault,
  input  logic ev_link_up,
  input  logic ev_lp_ack,
  input  logic ev_pd_fault,
  output logic irq_n
);
  logic [1:0]    sync_q;
  logic          mdc_d, mdc_rise;
  logic [AW-1:0] acc_addr, phy_addr;
  logic          rd_stb, wr_stb;
  logic [DW-1:0] wr_data, rd_data;
  logic [SRC_HI:SRC_LO] ev_lvl;

  pim_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mdc, mdio_in}), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_d <= 1'b0;
    else        mdc_d <= sync_q[1];
  end
  assign mdc_rise = sync_q[1] & ~mdc_d;

  assign ev_lvl = {ev_energy, ev_an_done, ev_rfault, ~ev_link_up, ev_lp_ack, ev_pd_fault};

  pim_mdio_slave u_slave (
    .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .bit_in(sync_q[0]),
    .my_addr(phy_addr), .rd_data(rd_data), .acc_addr(acc_addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  pim_src_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strap_addr0(strap_addr0), .ev_lvl(ev_lvl),
    .link_up(ev_link_up), .rfault(ev_rfault), .acc_addr(acc_addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data),
    .phy_addr(phy_addr), .irq_n(irq_n)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && !mdio_oe)); // R11
endmodule

// File: tb/phy_irq_mgmt_test.sv
module phy_irq_mgmt_test;
  logic clk = 0, rst_n = 0, strap_addr0 = 1, mdc = 0, mdio_in = 1;
  logic ev_energy = 0, ev_an_done = 0, ev_rfault = 0, ev_link_up = 0, ev_lp_ack = 0, ev_pd_fault = 0;
  logic mdio_out, mdio_oe, irq_n;
  int n_chk = 0, n_err = 0;
  logic [4:0] cur_pa = 5'd1;

  always #10 clk = ~clk;

  phy_irq_mgmt uut (.*);

  // {write?, reg, write data, expected read}
  localparam logic [37:0] VEC [5] = '{
    {1'b1, 5'd30, 16'h00FC, 16'h00FC},
    {1'b1, 5'd30, 16'hFFFF, 16'h00FC},
    {1'b1, 5'd2,  16'hABCD, 16'h0000},
    {1'b0, 5'd2,  16'h0000, 16'h0000},
    {1'b1, 5'd30, 16'h0000, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, input logic hit, output logic o, output logic oe);
    @(negedge clk); mdc = 0; mdio_in = b;
    repeat (3) @(negedge clk);
    o = mdio_out; oe = mdio_oe;
    mdc = 1;
    if (hit) begin
      repeat (2) @(negedge clk);
      ev_rfault = 1;        // lands on the edge that latches the register address
      repeat (2) @(negedge clk);
    end else repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] stb, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, input logic hit,
                       output logic [15:0] rd, output logic [2:0] ta, output logic any_oe);
    logic o, e;
    any_oe = 0; rd = '0; ta = '0;
    for (int i = 0; i < 32; i++) begin bit_io(1'b1, 1'b0, o, e); any_oe |= e; end
    bit_io(stb[1], 1'b0, o, e); any_oe |= e;
    bit_io(stb[0], 1'b0, o, e); any_oe |= e;
    bit_io(op[1], 1'b0, o, e); any_oe |= e;
    bit_io(op[0], 1'b0, o, e); any_oe |= e;
    for (int i = 4; i >= 0; i--) begin bit_io(pa[i], 1'b0, o, e); any_oe |= e; end
    for (int i = 4; i >= 0; i--) begin bit_io(ra[i], hit && i == 0, o, e); any_oe |= e; end
    if (op == 2'b10) begin
      bit_io(1'b1, 1'b0, o, e); ta[2] = e; any_oe |= e;
      bit_io(1'b1, 1'b0, o, e); ta[1] = e; ta[0] = o; any_oe |= e;
      for (int i = 15; i >= 0; i--) begin bit_io(1'b1, 1'b0, o, e); rd[i] = o; any_oe |= e; end
    end else begin
      bit_io(1'b1, 1'b0, o, e); any_oe |= e;
      bit_io(1'b0, 1'b0, o, e); any_oe |= e;
      for (int i = 15; i >= 0; i--) begin bit_io(wd[i], 1'b0, o, e); any_oe |= e; end
    end
  endtask

  task automatic mwr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] d; logic [2:0] t; logic a;
    frame(2'b01, 2'b01, pa, ra, wd, 1'b0, d, t, a);
  endtask

  task automatic rd_chk(input logic [4:0] ra, input logic [15:0] exp, input string tag);
    logic [15:0] d; logic [2:0] t; logic a, o, e;
    frame(2'b01, 2'b10, cur_pa, ra, 16'h0, 1'b0, d, t, a);
    chk(d == exp, tag, d, exp);
    chk(t == 3'b010, "R3 turnaround release then zero", {13'b0, t}, 16'h0002);
    bit_io(1'b1, 1'b0, o, e);
    bit_io(1'b1, 1'b0, o, e);
    chk(e == 1'b0, "R3 release after data", {15'b0, e}, 16'h0);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic run_all();
    logic [15:0] d; logic [2:0] t; logic a;
    repeat (5) @(negedge clk);
    rst_n = 1;
    settle();
    chk(irq_n == 1'b1, "R11 irq_n after reset", {15'b0, irq_n}, 16'h1);
    chk(mdio_oe == 1'b0, "R11 mdio_oe after reset", {15'b0, mdio_oe}, 16'h0);
    rd_chk(5'd29, 16'h0000, "R11 sources after reset");
    rd_chk(5'd30, 16'h0000, "R11 enables after reset");

    for (int i = 0; i < 5; i++) begin
      if (VEC[i][37]) mwr(cur_pa, VEC[i][36:32], VEC[i][31:16]);
      rd_chk(VEC[i][36:32], VEC[i][15:0], "R1 register vector");
    end

    // R2 address selection
    rd_chk(5'd18, 16'h0001, "R2 strap address");
    mwr(5'd0, 5'd30, 16'h00FC);
    rd_chk(5'd30, 16'h0000, "R2 write to other address ignored");
    frame(2'b01, 2'b10, 5'd0, 5'd30, 16'h0, 1'b0, d, t, a);
    chk(a == 1'b0, "R2 read to other address not driven", {15'b0, a}, 16'h0);
    mwr(cur_pa, 5'd18, 16'h0005);
    cur_pa = 5'd5;
    rd_chk(5'd18, 16'h0005, "R2 software address");
    frame(2'b01, 2'b10, 5'd1, 5'd18, 16'h0, 1'b0, d, t, a);
    chk(a == 1'b0, "R2 old address ignored", {15'b0, a}, 16'h0);

    // R4 malformed frames
    frame(2'b01, 2'b11, cur_pa, 5'd30, 16'h00FC, 1'b0, d, t, a);
    frame(2'b00, 2'b01, cur_pa, 5'd30, 16'h00FC, 1'b0, d, t, a);
    frame(2'b01, 2'b00, cur_pa, 5'd30, 16'h00FC, 1'b0, d, t, a);
    rd_chk(5'd30, 16'h0000, "R4 bad start or opcode ignored");

    // R5 latching
    ev_energy = 1; settle();
    rd_chk(5'd29, 16'h0080, "R5 energy source bit 7");
    ev_energy = 0;
    ev_link_up = 1; settle(); ev_link_up = 0; settle();
    rd_chk(5'd29, 16'h0010, "R5 link down source bit 4");
    ev_pd_fault = 1; settle();
    rd_chk(5'd29, 16'h0004, "R5 parallel fault source bit 2");

    // R6 clear on falling input
    ev_pd_fault = 0; ev_an_done = 1; settle(); ev_an_done = 0; settle();
    rd_chk(5'd29, 16'h0000, "R6 falling input clears source");

    // R7 read-clear rules
    ev_link_up = 1; settle(); ev_link_up = 0; settle(); ev_link_up = 1; settle();
    rd_chk(5'd29, 16'h0010, "R7 link down held after link returns");
    ev_rfault = 1; ev_lp_ack = 1; settle();
    rd_chk(5'd1, 16'h781D, "R10 status live bits");
    rd_chk(5'd29, 16'h0008, "R7 status read clears only bits 4 and 5");
    ev_rfault = 0; ev_lp_ack = 0; settle();

    // R9 interrupt masking
    mwr(cur_pa, 5'd30, 16'h0040);
    ev_an_done = 1; settle();
    chk(irq_n == 1'b0, "R9 enabled source asserts irq_n", {15'b0, irq_n}, 16'h0);
    mwr(cur_pa, 5'd30, 16'h0080);
    settle();
    chk(irq_n == 1'b1, "R9 clearing enable releases irq_n", {15'b0, irq_n}, 16'h1);
    mwr(cur_pa, 5'd30, 16'h0040);
    settle();
    chk(irq_n == 1'b0, "R9 re-enable asserts irq_n", {15'b0, irq_n}, 16'h0);
    rd_chk(5'd29, 16'h0040, "R9 source seen");
    settle();
    chk(irq_n == 1'b1, "R9 read clear releases irq_n", {15'b0, irq_n}, 16'h1);
    mwr(cur_pa, 5'd30, 16'h0000);
    ev_an_done = 0; settle();

    // R8 set and read-clear in one cycle
    frame(2'b01, 2'b10, cur_pa, 5'd29, 16'h0, 1'b1, d, t, a);
    chk(d == 16'h0000, "R8 colliding read returns old value", d, 16'h0000);
    rd_chk(5'd29, 16'h0020, "R8 set wins over read clear");
    ev_rfault = 0; settle();

    // R10 restart bit
    mwr(cur_pa, 5'd0, 16'h3200);
    rd_chk(5'd0, 16'h3000, "R10 restart bit self clears");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule